// File: doc/BRIEF.md
# Flash Command Interface Mode Decoder

This block models the command front end of a parallel NOR-style flash device. Host bus writes carry a command byte in the low eight data bits. Most commands select a sticky read mode that decides what every later host read returns. The modes are memory-array contents, configuration data (identifier codes, per-block lock words and protection-register words), the status register, and words from an external query table. The mode holds until another recognised command arrives.

Programming takes two bus writes. The setup byte 40h arms the block. The next write is taken as the target address and data, not as a command. It fires a one-cycle start strobe toward the write state machine, and the block then switches to status mode so that polling reads show progress. Error flags reported by the write state machine stay set until the clear command 50h or a reset.

All lookups are combinational on the host address through one shared address output. The block registers the read result and returns it one cycle after the read with a valid flag.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the block is in array mode, no program setup is pending, all status error flags are clear, and `host_rvalid`, `host_rdata` and `pgm_start` are zero.
- R2: After command FFh, a read returns `arr_rdata` for the read address.
- R3: After command 90h, a read of address 0 returns 0089h and a read of address 1 returns the `DEV_ID` parameter.
- R4: In configuration mode, a read whose offset within its block (the low `OFF_W` address bits) equals 2 returns `{14'b0, lock_state}`, where bit 0 means locked and bit 1 means locked-down.
- R5: In configuration mode, reads of addresses 80h through 88h return `otp_rdata`: 80h is the protection lock word and 81h–88h are the eight protection words.
- R6: In configuration mode, every other address reads as 0000h.
- R7: After command 70h, a read returns the status word: bits 15:8 are zero, bit 7 is `~wsm_busy`, bits 5, 4, 3 and 1 are sticky copies of `wsm_err[3]`, `wsm_err[2]`, `wsm_err[1]` and `wsm_err[0]`, and bits 6, 2 and 0 are zero.
- R8: After command 98h, a read returns `qry_rdata`.
- R9: After setup byte 40h, the next write makes `pgm_start` high for exactly one cycle on the following clock. During that cycle `pgm_addr` and `pgm_data` hold the write's address and data, and the mode becomes status.
- R10: The write that follows 40h is not decoded as a command, so a data value of FFh there does not select array mode.
- R11: Command 50h clears all sticky error flags and leaves the mode unchanged. A flag raised in the same cycle as the clear stays set.
- R12: A command byte that is not FFh, 90h, 70h, 98h, 40h or 50h leaves the mode unchanged.
- R13: A read (`host_ce` and `host_oe` high, `host_we` low) gives `host_rvalid` high on the next cycle with the data. `host_rvalid` is low in every other cycle, and a write is never taken as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ce | input | 1 | Chip enable |
| host_we | input | 1 | Write enable (write when with `host_ce`) |
| host_oe | input | 1 | Output enable (read when with `host_ce` and not `host_we`) |
| host_addr | input | AW | Host word address |
| host_wdata | input | 16 | Host write data / command byte in bits 7:0 |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| look_addr | output | AW | Shared lookup address for array, query, lock and protection ports |
| arr_rdata | input | 16 | Memory array word at `look_addr` |
| qry_rdata | input | 16 | Query table word at `look_addr` |
| otp_rdata | input | 16 | Protection-register word at `look_addr` |
| lock_state | input | 2 | Lock bits of the block containing `look_addr` |
| wsm_busy | input | 1 | Write state machine busy |
| wsm_err | input | 4 | Error flags raised by the write state machine (sticky inside) |
| pgm_start | output | 1 | One-cycle program start strobe |
| pgm_addr | output | AW | Program target address |
| pgm_data | output | 16 | Program data |

## Verification
The hardest case to reach from the ports is the program data write whose data is FFh. Only the armed state tells this write apart from a return to array mode, and it must not change the mode. The stimulus issues 40h and then a write carrying FFh, and reads straight away to confirm that status data, not array data, comes back. A related corner is a clear command that arrives in the same cycle as a new error flag. The bench drives `wsm_err` during the 50h write and then reads status to confirm that the new flag survives.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {
    MD_ARRAY  = 2'd0,
    MD_CONFIG = 2'd1,
    MD_STATUS = 2'd2,
    MD_QUERY  = 2'd3
  } mode_e;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_CONFIG = 8'h90;
  localparam logic [7:0] CMD_STATUS = 8'h70;
  localparam logic [7:0] CMD_QUERY  = 8'h98;
  localparam logic [7:0] CMD_SETUP  = 8'h40;
  localparam logic [7:0] CMD_CLEAR  = 8'h50;
endpackage

// File: rtl/fcd_cmd_ctrl.sv
module fcd_cmd_ctrl
  import fcd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output mode_e         mode,
  output logic          pend,
  output logic          clr_err,
  output logic          pgm_start,
  output logic [AW-1:0] pgm_addr,
  output logic [DW-1:0] pgm_data
);
  logic [7:0] cmd;
  assign cmd     = wdata[7:0];
  assign clr_err = wr && !pend && (cmd == CMD_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MD_ARRAY;
      pend      <= 1'b0;
      pgm_start <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
    end else begin
      pgm_start <= 1'b0;
      if (wr) begin
        if (pend) begin
          pgm_start <= 1'b1;
          pgm_addr  <= addr;
          pgm_data  <= wdata;
          pend      <= 1'b0;
          mode      <= MD_STATUS;
        end else begin
          case (cmd)
            CMD_ARRAY:  mode <= MD_ARRAY;
            CMD_CONFIG: mode <= MD_CONFIG;
            CMD_STATUS: mode <= MD_STATUS;
            CMD_QUERY:  mode <= MD_QUERY;
            CMD_SETUP:  pend <= 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/fcd_status.sv
module fcd_status #(
  parameter int NERR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [NERR-1:0] err_in,
  input  logic            busy,
  output logic [15:0]     word
);
  logic [NERR-1:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= (clr ? '0 : err_q) | err_in;
  end

  // flags 3..1 sit at bits 5..3, flag 0 at bit 1
  assign word = {8'h00, ~busy, 1'b0, err_q[3], err_q[2], err_q[1], 1'b0, err_q[0], 1'b0};
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int          AW     = 20,
  parameter int          OFF_W  = 16,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h00D7
) (
  input  mode_e         mode,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   arr_rdata,
  input  logic [15:0]   qry_rdata,
  input  logic [15:0]   otp_rdata,
  input  logic [1:0]    lock_state,
  input  logic [15:0]   sts_word,
  output logic [15:0]   word
);
  localparam logic [AW-1:0] A_MFR   = AW'(0);
  localparam logic [AW-1:0] A_DEV   = AW'(1);
  localparam logic [AW-1:0] A_OTPLO = AW'('h80);
  localparam logic [AW-1:0] A_OTPHI = AW'('h88);
  localparam logic [OFF_W-1:0] O_LOCK = OFF_W'(2);

  logic [15:0] cfg_word;

  always_comb begin
    if (addr == A_MFR)                         cfg_word = MFR_ID;
    else if (addr == A_DEV)                    cfg_word = DEV_ID;
    else if (addr[OFF_W-1:0] == O_LOCK)        cfg_word = {14'b0, lock_state};
    else if (addr >= A_OTPLO && addr <= A_OTPHI) cfg_word = otp_rdata;
    else                                       cfg_word = 16'h0000;
  end

  always_comb begin
    case (mode)
      MD_CONFIG: word = cfg_word;
      MD_STATUS: word = sts_word;
      MD_QUERY:  word = qry_rdata;
      default:   word = arr_rdata;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int          AW     = 20,
  parameter int          OFF_W  = 16,
  parameter logic [15:0] DEV_ID = 16'h00D7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_ce,
  input  logic          host_we,
  input  logic          host_oe,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          host_rvalid,
  output logic [AW-1:0] look_addr,
  input  logic [15:0]   arr_rdata,
  input  logic [15:0]   qry_rdata,
  input  logic [15:0]   otp_rdata,
  input  logic [1:0]    lock_state,
  input  logic          wsm_busy,
  input  logic [3:0]    wsm_err,
  output logic          pgm_start,
  output logic [AW-1:0] pgm_addr,
  output logic [15:0]   pgm_data
);
  localparam int DW = 16;

  logic        wr, rd, pend, clr_err;
  mode_e       mode;
  logic [15:0] sts_word, rd_word;

  assign wr        = host_ce && host_we;
  assign rd        = host_ce && host_oe && !host_we;
  assign look_addr = host_addr;

  fcd_cmd_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .wr(wr), .addr(host_addr), .wdata(host_wdata),
    .mode(mode), .pend(pend), .clr_err(clr_err), .pgm_start(pgm_start),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data)
  );

  fcd_status #(.NERR(4)) u_sts (
    .clk(clk), .rst(rst), .clr(clr_err), .err_in(wsm_err),
    .busy(wsm_busy), .word(sts_word)
  );

  fcd_read_mux #(.AW(AW), .OFF_W(OFF_W), .DEV_ID(DEV_ID)) u_mux (
    .mode(mode), .addr(host_addr), .arr_rdata(arr_rdata), .qry_rdata(qry_rdata),
    .otp_rdata(otp_rdata), .lock_state(lock_state), .sts_word(sts_word),
    .word(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= rd;
      if (rd) host_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          wr,
  input logic          rd,
  input logic          pend,
  input mode_e         mode,
  input logic [15:0]   host_wdata,
  input logic [3:0]    wsm_err,
  input logic [15:0]   sts_word,
  input logic          host_rvalid,
  input logic [15:0]   host_rdata,
  input logic          pgm_start
);
  logic rst_d = 1'b0;
  always @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d) AST_RESET_QUIET: assert (!pgm_start && !host_rvalid); // R1

  AST_PGM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pgm_start |=> !pgm_start); // R9
  AST_PGM_TO_STATUS: assert property (@(posedge clk) disable iff (rst)
    pgm_start |-> mode == MD_STATUS); // R9
  AST_PGM_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr && pend) |=> pgm_start); // R9
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    rd |=> host_rvalid); // R13
  AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !host_rvalid); // R13
  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && mode == MD_STATUS) |=> host_rdata[15:8] == 8'h00); // R7
  AST_CLEAR_ERRS: assert property (@(posedge clk) disable iff (rst)
    (wr && !pend && host_wdata[7:0] == CMD_CLEAR && wsm_err == 4'b0)
      |=> (sts_word[5:3] == 3'b0 && sts_word[1] == 1'b0)); // R11
  AST_UNKNOWN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr && !pend && host_wdata[7:0] == 8'h00) |=> $stable(mode)); // R12
endmodule

bind flash_cmd_decoder fcd_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr(wr), .rd(rd), .pend(pend), .mode(mode),
  .host_wdata(host_wdata), .wsm_err(wsm_err), .sts_word(sts_word),
  .host_rvalid(host_rvalid), .host_rdata(host_rdata), .pgm_start(pgm_start)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 20;
  localparam logic [15:0] DEVID = 16'h00D7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_ce = 0, host_we = 0, host_oe = 0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_rvalid;
  logic [AW-1:0] look_addr;
  logic [15:0] arr_rdata, qry_rdata, otp_rdata;
  logic [1:0] lock_state;
  logic wsm_busy = 1'b0;
  logic [3:0] wsm_err = 4'b0;
  logic pgm_start;
  logic [AW-1:0] pgm_addr;
  logic [15:0] pgm_data;

  always #4 clk = ~clk;

  assign arr_rdata  = look_addr[15:0] ^ 16'hA5A5;
  assign qry_rdata  = look_addr[15:0] + 16'h1000;
  assign otp_rdata  = {look_addr[7:0], 8'h3C};
  assign lock_state = look_addr[17:16];

  flash_cmd_decoder #(.AW(AW), .OFF_W(16), .DEV_ID(DEVID)) u_flash_cmd_decoder (
    .clk(clk), .rst(rst), .host_ce(host_ce), .host_we(host_we), .host_oe(host_oe),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .look_addr(look_addr), .arr_rdata(arr_rdata),
    .qry_rdata(qry_rdata), .otp_rdata(otp_rdata), .lock_state(lock_state),
    .wsm_busy(wsm_busy), .wsm_err(wsm_err), .pgm_start(pgm_start),
    .pgm_addr(pgm_addr), .pgm_data(pgm_data)
  );

  int checks = 0, fails = 0;
  bit done = 0, chk_en = 0;
  string cur_tag = "R1", exp_tag = "R1";

  // behavioural reference: mode 0 array, 1 config, 2 status, 3 query
  int m_mode = 0;
  bit m_pend = 0;
  bit [3:0] m_err = 0;
  bit [15:0] exp_rdata = 0, exp_pdata = 0;
  bit [AW-1:0] exp_paddr = 0;
  bit exp_rvalid = 0, exp_pstart = 0;

  function automatic bit [15:0] ref_read(int md, bit [AW-1:0] a);
    case (md)
      1: begin
        if (a == 0) return 16'h0089;
        if (a == 1) return DEVID;
        if (a[15:0] == 16'd2) return {14'b0, a[17:16]};
        if (a >= 'h80 && a <= 'h88) return {a[7:0], 8'h3C};
        return 16'h0000;
      end
      2: return {8'h00, ~wsm_busy, 1'b0, m_err[3], m_err[2], m_err[1], 1'b0, m_err[0], 1'b0};
      3: return a[15:0] + 16'h1000;
      default: return a[15:0] ^ 16'hA5A5;
    endcase
  endfunction

  always @(posedge clk) begin
    exp_tag <= cur_tag;
    if (rst) begin
      m_mode = 0; m_pend = 0; m_err = 0;
      exp_rvalid <= 0; exp_rdata <= 0; exp_pstart <= 0; exp_paddr <= 0; exp_pdata <= 0;
      chk_en <= 1;
    end else begin
      exp_pstart <= 0;
      exp_rvalid <= host_ce && host_oe && !host_we;
      if (host_ce && host_oe && !host_we) exp_rdata <= ref_read(m_mode, host_addr);
      if (host_ce && host_we) begin
        if (m_pend) begin
          exp_pstart <= 1; exp_paddr <= host_addr; exp_pdata <= host_wdata;
          m_pend = 0; m_mode = 2;
          m_err = m_err | wsm_err;
        end else begin
          case (host_wdata[7:0])
            8'hFF: m_mode = 0;
            8'h90: m_mode = 1;
            8'h70: m_mode = 2;
            8'h98: m_mode = 3;
            8'h40: m_pend = 1;
            default: ;
          endcase
          if (host_wdata[7:0] == 8'h50) m_err = wsm_err;
          else m_err = m_err | wsm_err;
        end
      end else m_err = m_err | wsm_err;
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_en && !done) begin
    check("R13", "rvalid", 32'(host_rvalid), 32'(exp_rvalid));
    check(exp_tag, "rdata", 32'(host_rdata), 32'(exp_rdata));
    check("R9", "pgm_start", 32'(pgm_start), 32'(exp_pstart));
    if (exp_pstart) begin
      check("R9", "pgm_addr", 32'(pgm_addr), 32'(exp_paddr));
      check("R9", "pgm_data", 32'(pgm_data), 32'(exp_pdata));
    end
  end

  task automatic wr_op(input bit [AW-1:0] a, input bit [15:0] d, input string tag);
    cur_tag = tag;
    @(negedge clk); host_ce = 1; host_we = 1; host_oe = 0; host_addr = a; host_wdata = d;
    @(negedge clk); host_ce = 0; host_we = 0;
  endtask

  task automatic rd_op(input bit [AW-1:0] a, input string tag);
    cur_tag = tag;
    @(negedge clk); host_ce = 1; host_oe = 1; host_we = 0; host_addr = a;
    @(negedge clk); host_ce = 0; host_oe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    rd_op('h00010, "R2"); rd_op('h3ABCD, "R2"); rd_op('h00002, "R2");
    wr_op('h00000, 16'h0090, "R3");
    rd_op('h00000, "R3"); rd_op('h00001, "R3");
    rd_op('h30002, "R4"); rd_op('h10002, "R4"); rd_op('h00002, "R4");
    rd_op('h00080, "R5"); rd_op('h00085, "R5"); rd_op('h00088, "R5");
    rd_op('h00003, "R6"); rd_op('h00089, "R6"); rd_op('h20000, "R6"); rd_op('h0007F, "R6");
    @(negedge clk); wsm_err = 4'b0101; @(negedge clk); wsm_err = 4'b0;
    wsm_busy = 1;
    wr_op('h00000, 16'h0070, "R7");
    rd_op('h00000, "R7");
    wsm_busy = 0;
    rd_op('h00004, "R7");
    wr_op('h00000, 16'h0000, "R12"); rd_op('h00000, "R12");
    wr_op('h00000, 16'h00A3, "R12"); rd_op('h00000, "R12");
    wr_op('h00000, 16'h0050, "R11"); rd_op('h00000, "R11");
    cur_tag = "R11";
    @(negedge clk); host_ce = 1; host_we = 1; host_addr = 0; host_wdata = 16'h0050; wsm_err = 4'b1000;
    @(negedge clk); host_ce = 0; host_we = 0; wsm_err = 4'b0;
    rd_op('h00000, "R11");
    wr_op('h00000, 16'h0050, "R11"); rd_op('h00000, "R11");
    wr_op('h00000, 16'h0098, "R8"); rd_op('h00007, "R8"); rd_op('h2FFFF, "R8");
    wr_op('h00000, 16'h00FF, "R2"); rd_op('h00123, "R2");
    wr_op('h00000, 16'h0040, "R9");
    wr_op('h01234, 16'h00FF, "R10");
    rd_op('h01234, "R10");
    wr_op('h00000, 16'h0040, "R9");
    wr_op('h3FFFF, 16'hBEEF, "R9");
    rd_op('h00000, "R9");
    wr_op('h00000, 16'h00FF, "R2"); rd_op('h00456, "R2");
    cur_tag = "R1";
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    rd_op('h00099, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule